// File: doc/BRIEF.md
# AES-128 Round-Key Step Unit

This unit derives the next AES-128 round key from the current one, one 128-bit element group at a time. A command fixes the element width code, the first element index, the vector length and a 5-bit round immediate. The unit checks the command for legality, then consumes one input group per handshake on a key stream and returns the following round key on an output stream. Each result is tagged with its group index and a flag on the final group.

Each group is four 32-bit elements. Every element is byte-reversed into an AES word (w0..w3). The unit rotates and substitutes the last word, mixes in the round constant chosen by the repaired immediate, and chains the XORs across the other words. The result is byte-reversed back into element order.

Both data interfaces are valid/ready. A command is taken only when `cmd_valid` and `cmd_ready` are high together. An input group is taken only when `in_valid` and `in_ready` are high together. The output stage holds one result. While `out_valid` is high and `out_ready` is low, that result stays frozen and `in_ready` drops, so back-pressure reaches the input in the same cycle. Both valids may be raised freely. Nothing is taken without the matching ready.

Top module: `ks_step_unit`

## Requirements
- R1: Only `cmd_imm[3:0]` is used and bit 4 is ignored. If that 4-bit value is 0 or above 10, its bit 3 is inverted to form the round number r. So 0→8, 11→3, 12→4, 13→5, 14→6 and 15→7.
- R2: The round constant for round r is a byte placed in bits 31:24 of a word. Rounds 1 to 8 give 01,02,04,08,10,20,40,80 and rounds 9 and 10 give 1B and 36.
- R3: The new first word is w0 ^ S(rot(w3)) ^ rcon. rot moves bits 31:24 of w3 down to bits 7:0. S applies the AES S-box to each byte.
- R4: The other new words chain: n1 = w1^n0, n2 = w2^n1, n3 = w3^n2.
- R5: Element e occupies bits 32e+31:32e of `in_key` and `out_key`. Its bits 7:0 become bits 31:24 of AES word we. Outputs use the same mapping.
- R6: A command is legal only if `cmd_sew` is 2 (32-bit elements) and the low two bits of both `cmd_vstart` and `cmd_vl` are zero. An accepted illegal command pulses `cmd_illegal` for one cycle in the following cycle. It consumes no group: `in_ready` stays low and `cmd_ready` stays high.
- R7: A legal command processes groups `cmd_vstart/4` up to `cmd_vl/4 - 1` in order. `out_group` gives each group's index and `out_last` marks the final one. If `cmd_vstart >= cmd_vl`, no group is consumed.
- R8: A result appears on the output with `out_valid` high in the cycle after its input handshake.
- R9: While `out_valid` is high and `out_ready` is low, `out_key`, `out_group` and `out_last` hold steady and `in_ready` is low.
- R10: `cmd_ready` is high only when no group of the current command is pending. `in_ready` is high only while a group is pending. The two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Unit can take a command |
| cmd_vstart | input | VL_W | First element index |
| cmd_vl | input | VL_W | Vector length in elements |
| cmd_sew | input | 3 | Element width code (2 = 32-bit) |
| cmd_imm | input | 5 | Round immediate |
| cmd_illegal | output | 1 | One-cycle pulse after an illegal command |
| in_valid | input | 1 | Current key group offered |
| in_ready | output | 1 | Unit can take a key group |
| in_key | input | 128 | Current round key, four elements |
| out_valid | output | 1 | Next key available |
| out_ready | input | 1 | Consumer takes the result |
| out_key | output | 128 | Next round key, four elements |
| out_group | output | VL_W-2 | Group index of this result |
| out_last | output | 1 | Final group of the command |

## Verification
The assertions check the stream rules on every cycle. They cover output hold under back-pressure, the one-cycle latency from input handshake to result, the source and timing of the illegal-command pulse, and the mutual exclusion of the two ready signals. The key arithmetic cannot be seen by a cycle property: immediate repair, round-constant choice, substitution, rotation, chaining and byte order. Only the bench scenarios can show it, by comparing against an independently built reference. The same holds for group ordering, the last-group flag and empty ranges.

// File: rtl/ks_pkg.sv
package ks_pkg;

  localparam int unsigned KS_WORDS = 4;
  localparam int unsigned KS_WORD_W = 32;
  localparam int unsigned KS_KEY_W = KS_WORDS * KS_WORD_W;
  localparam logic [2:0] KS_SEW_32 = 3'd2;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } ks_state_e;

  function automatic logic [7:0] gf_xtime(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = 8'h00;
    sh = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = gf_xtime(sh);
    end
    return acc;
  endfunction

  // multiplicative inverse as a^254; zero maps to zero
  function automatic logic [7:0] gf_inv(input logic [7:0] a);
    logic [7:0] res;
    logic [7:0] base;
    res = 8'h01;
    base = a;
    for (int i = 0; i < 8; i++) begin
      if (i != 0) res = gf_mul(res, base);
      base = gf_mul(base, base);
    end
    return res;
  endfunction

  function automatic logic [7:0] sbox_calc(input logic [7:0] x);
    logic [7:0] v;
    v = gf_inv(x);
    return v ^ {v[6:0], v[7]} ^ {v[5:0], v[7:6]} ^ {v[4:0], v[7:5]} ^
           {v[3:0], v[7:4]} ^ 8'h63;
  endfunction

  function automatic logic [31:0] bswap32(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  // round constant byte: doubling of 01 applied (r-1) times
  function automatic logic [7:0] rcon_of(input logic [3:0] r);
    logic [7:0] rc;
    rc = 8'h01;
    for (int i = 1; i < 16; i++) begin
      if (i < int'(r)) rc = gf_xtime(rc);
    end
    return rc;
  endfunction

endpackage

// File: rtl/ks_sbox.sv
module ks_sbox (
  input  logic [7:0] din,
  output logic [7:0] dout
);
  import ks_pkg::*;

  always_comb dout = sbox_calc(din);

endmodule

// File: rtl/ks_round_fix.sv
module ks_round_fix (
  input  logic [4:0] imm,
  output logic [3:0] round,
  output logic [7:0] rcon
);
  import ks_pkg::*;

  logic [3:0] raw;

  always_comb begin
    raw = imm[3:0];
    if (raw == 4'd0 || raw > 4'd10) round = raw ^ 4'b1000;
    else round = raw;
    rcon = rcon_of(round);
  end

endmodule

// File: rtl/ks_word_expand.sv
module ks_word_expand
  import ks_pkg::*;
(
  input  logic [KS_KEY_W-1:0] key_in,
  input  logic [7:0]          rcon,
  output logic [KS_KEY_W-1:0] key_out
);

  logic [KS_WORDS-1:0][KS_WORD_W-1:0] aw;
  logic [KS_WORDS-1:0][KS_WORD_W-1:0] nw;
  logic [KS_WORD_W-1:0] rot;
  logic [KS_WORD_W-1:0] sub;

  genvar gi;
  generate
    for (gi = 0; gi < KS_WORDS; gi++) begin : g_in
      assign aw[gi] = bswap32(key_in[KS_WORD_W*gi +: KS_WORD_W]);
    end
  endgenerate

  assign rot = {aw[KS_WORDS-1][23:0], aw[KS_WORDS-1][31:24]};

  generate
    for (gi = 0; gi < KS_WORD_W/8; gi++) begin : g_sub
      ks_sbox u_sbox (
        .din (rot[8*gi +: 8]),
        .dout(sub[8*gi +: 8])
      );
    end
  endgenerate

  assign nw[0] = aw[0] ^ sub ^ {rcon, 24'h000000};

  generate
    for (gi = 1; gi < KS_WORDS; gi++) begin : g_chain
      assign nw[gi] = aw[gi] ^ nw[gi-1];
    end
    for (gi = 0; gi < KS_WORDS; gi++) begin : g_out
      assign key_out[KS_WORD_W*gi +: KS_WORD_W] = bswap32(nw[gi]);
    end
  endgenerate

endmodule

// File: rtl/ks_group_ctl.sv
module ks_group_ctl
  import ks_pkg::*;
#(
  parameter int unsigned VL_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [VL_W-1:0]   cmd_vstart,
  input  logic [VL_W-1:0]   cmd_vl,
  input  logic [2:0]        cmd_sew,
  input  logic [4:0]        cmd_imm,
  input  logic              grp_fire,
  output logic              cmd_ready,
  output logic              cmd_illegal,
  output logic              busy,
  output logic [VL_W-3:0]   grp_idx,
  output logic              grp_last,
  output logic [4:0]        imm_q
);

  localparam int unsigned IDX_W = VL_W - 2;

  ks_state_e        state;
  logic [IDX_W-1:0] last_q;
  logic             legal;
  logic             accept;
  logic [IDX_W-1:0] first_grp;
  logic [IDX_W-1:0] end_grp;

  assign legal = (cmd_sew == KS_SEW_32) && (cmd_vstart[1:0] == 2'b00) &&
                 (cmd_vl[1:0] == 2'b00);
  assign cmd_ready = (state == ST_IDLE);
  assign busy = (state == ST_RUN);
  assign accept = cmd_valid && cmd_ready;
  assign first_grp = cmd_vstart[VL_W-1:2];
  assign end_grp = cmd_vl[VL_W-1:2];
  assign grp_last = (grp_idx == last_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      cmd_illegal <= 1'b0;
      grp_idx     <= '0;
      last_q      <= '0;
      imm_q       <= '0;
    end else begin
      cmd_illegal <= accept && !legal;
      if (accept && legal && (cmd_vstart < cmd_vl)) begin
        state   <= ST_RUN;
        grp_idx <= first_grp;
        last_q  <= end_grp - 1'b1;
        imm_q   <= cmd_imm;
      end else if (busy && grp_fire) begin
        grp_idx <= grp_idx + 1'b1;
        if (grp_last) state <= ST_IDLE;
      end
    end
  end

endmodule

// File: rtl/ks_step_unit.sv
module ks_step_unit
  import ks_pkg::*;
#(
  parameter int unsigned VL_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  output logic                cmd_ready,
  input  logic [VL_W-1:0]     cmd_vstart,
  input  logic [VL_W-1:0]     cmd_vl,
  input  logic [2:0]          cmd_sew,
  input  logic [4:0]          cmd_imm,
  output logic                cmd_illegal,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [KS_KEY_W-1:0] in_key,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [KS_KEY_W-1:0] out_key,
  output logic [VL_W-3:0]     out_group,
  output logic                out_last
);

  logic             busy;
  logic [VL_W-3:0]  grp_idx;
  logic             grp_last;
  logic [4:0]       imm_q;
  logic [3:0]       round;
  logic [7:0]       rcon;
  logic [KS_KEY_W-1:0] next_key;
  logic             fire;

  assign in_ready = busy && (!out_valid || out_ready);
  assign fire = in_valid && in_ready;

  ks_group_ctl #(.VL_W(VL_W)) u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_vstart (cmd_vstart),
    .cmd_vl     (cmd_vl),
    .cmd_sew    (cmd_sew),
    .cmd_imm    (cmd_imm),
    .grp_fire   (fire),
    .cmd_ready  (cmd_ready),
    .cmd_illegal(cmd_illegal),
    .busy       (busy),
    .grp_idx    (grp_idx),
    .grp_last   (grp_last),
    .imm_q      (imm_q)
  );

  ks_round_fix u_fix (
    .imm  (imm_q),
    .round(round),
    .rcon (rcon)
  );

  ks_word_expand u_exp (
    .key_in (in_key),
    .rcon   (rcon),
    .key_out(next_key)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_key   <= '0;
      out_group <= '0;
      out_last  <= 1'b0;
    end else if (fire) begin
      out_valid <= 1'b1;
      out_key   <= next_key;
      out_group <= grp_idx;
      out_last  <= grp_last;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/ks_step_unit_chk.sv
module ks_step_unit_chk #(
  parameter int unsigned VL_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cmd_valid,
  input logic            cmd_ready,
  input logic [VL_W-1:0] cmd_vstart,
  input logic [VL_W-1:0] cmd_vl,
  input logic [2:0]      cmd_sew,
  input logic            cmd_illegal,
  input logic            in_valid,
  input logic            in_ready,
  input logic            out_valid,
  input logic            out_ready,
  input logic [127:0]    out_key,
  input logic [VL_W-3:0] out_group,
  input logic            out_last
);

  logic bad_cmd;
  assign bad_cmd = (cmd_sew != 3'd2) || (cmd_vstart[1:0] != 2'b00) ||
                   (cmd_vl[1:0] != 2'b00);

  assert_out_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_key) &&
    $stable(out_group) && $stable(out_last));

  assert_stall_in_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready));

  assert_illegal_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_illegal |-> $past(cmd_valid && cmd_ready && bad_cmd));

  assert_illegal_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && bad_cmd |=> cmd_illegal && !in_ready && cmd_ready);

  assert_ready_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_ready && in_ready));

endmodule

bind ks_step_unit ks_step_unit_chk #(.VL_W(VL_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_ready  (cmd_ready),
  .cmd_vstart (cmd_vstart),
  .cmd_vl     (cmd_vl),
  .cmd_sew    (cmd_sew),
  .cmd_illegal(cmd_illegal),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_key    (out_key),
  .out_group  (out_group),
  .out_last   (out_last)
);

// File: tb/tb_ks_step_unit.sv
module tb_ks_step_unit;
  localparam int VL_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [VL_W-1:0] cmd_vstart = '0;
  logic [VL_W-1:0] cmd_vl = '0;
  logic [2:0] cmd_sew = 3'd0;
  logic [4:0] cmd_imm = 5'd0;
  logic cmd_illegal;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [127:0] in_key = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [127:0] out_key;
  logic [VL_W-3:0] out_group;
  logic out_last;

  int checks = 0;
  int fails = 0;
  logic [7:0] sb [256];

  always #4 clk = ~clk;

  ks_step_unit #(.VL_W(VL_W)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_vstart(cmd_vstart), .cmd_vl(cmd_vl), .cmd_sew(cmd_sew),
    .cmd_imm(cmd_imm), .cmd_illegal(cmd_illegal), .in_valid(in_valid),
    .in_ready(in_ready), .in_key(in_key), .out_valid(out_valid),
    .out_ready(out_ready), .out_key(out_key), .out_group(out_group),
    .out_last(out_last)
  );

  task automatic check(input logic ok, input string tag,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] rotl8(input logic [7:0] v, input int n);
    return (v << n) | (v >> (8 - n));
  endfunction

  task automatic build_sbox();
    logic [7:0] p, q, x;
    p = 8'h01;
    q = 8'h01;
    sb[0] = 8'h63;
    do begin
      p = p ^ {p[6:0], 1'b0} ^ (p[7] ? 8'h1b : 8'h00);
      q = q ^ {q[6:0], 1'b0};
      q = q ^ {q[5:0], 2'b00};
      q = q ^ {q[3:0], 4'h0};
      if (q[7]) q = q ^ 8'h09;
      x = q ^ rotl8(q, 1) ^ rotl8(q, 2) ^ rotl8(q, 3) ^ rotl8(q, 4);
      sb[p] = x ^ 8'h63;
    end while (p != 8'h01);
  endtask

  function automatic logic [31:0] sw(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  // R1, R2, R3, R4, R5 reference
  function automatic logic [127:0] exp_next(input logic [127:0] k, input logic [4:0] imm);
    logic [3:0] r;
    logic [7:0] rc;
    logic [31:0] w [4];
    logic [31:0] n [4];
    logic [31:0] t;
    logic [7:0] tbl [10];
    logic [127:0] res;
    tbl = '{8'h01, 8'h02, 8'h04, 8'h08, 8'h10, 8'h20, 8'h40, 8'h80, 8'h1b, 8'h36};
    r = imm[3:0];
    if (r == 4'd0 || r > 4'd10) r = r ^ 4'd8;
    rc = tbl[r - 1];
    for (int i = 0; i < 4; i++) w[i] = sw(k[32*i +: 32]);
    t = {w[3][23:0], w[3][31:24]};
    t = {sb[t[31:24]], sb[t[23:16]], sb[t[15:8]], sb[t[7:0]]};
    n[0] = w[0] ^ t ^ {rc, 24'h0};
    for (int i = 1; i < 4; i++) n[i] = w[i] ^ n[i-1];
    for (int i = 0; i < 4; i++) res[32*i +: 32] = sw(n[i]);
    return res;
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom(), $urandom(), $urandom(), $urandom()};
  endfunction

  task automatic run_cmd(input int vs, input int vl, input logic [2:0] sew,
                         input logic [4:0] imm, input logic [127:0] first_key,
                         input logic use_first, input int max_stall);
    logic legal;
    logic [127:0] k, e;
    int nstall;
    legal = (sew == 3'd2) && (vs % 4 == 0) && (vl % 4 == 0);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_vstart = VL_W'(vs);
    cmd_vl = VL_W'(vl);
    cmd_sew = sew;
    cmd_imm = imm;
    check(cmd_ready === 1'b1, "R10 cmd_ready idle", {127'd0, cmd_ready}, 128'd1);
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    check(cmd_illegal === !legal, "R6 illegal pulse", {127'd0, cmd_illegal}, {127'd0, !legal});
    if (!legal || vs >= vl) begin
      check(in_ready === 1'b0 && cmd_ready === 1'b1, "R6 R7 no group taken",
            {126'd0, in_ready, cmd_ready}, 128'd1);
      @(negedge clk);
      check(cmd_illegal === 1'b0, "R6 pulse one cycle", {127'd0, cmd_illegal}, 128'd0);
      return;
    end
    check(cmd_ready === 1'b0, "R10 cmd_ready busy", {127'd0, cmd_ready}, 128'd0);
    for (int g = vs / 4; g < vl / 4; g++) begin
      k = (use_first && g == vs / 4) ? first_key : rnd128();
      e = exp_next(k, imm);
      in_valid = 1'b1;
      in_key = k;
      check(in_ready === 1'b1, "R10 in_ready pending", {127'd0, in_ready}, 128'd1);
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      check(out_valid === 1'b1, "R8 out_valid next cycle", {127'd0, out_valid}, 128'd1);
      check(out_key === e, "R3 R4 R5 next key", out_key, e);
      check(out_group === (VL_W-2)'(g), "R7 group index", 128'(out_group), 128'(g));
      check(out_last === (g == vl / 4 - 1), "R7 last flag", {127'd0, out_last},
            {127'd0, (g == vl / 4 - 1)});
      nstall = (max_stall > 0) ? int'($urandom() % (max_stall + 1)) : 0;
      for (int s = 0; s < nstall; s++) begin
        @(negedge clk);
        check(out_valid === 1'b1 && out_key === e && in_ready === 1'b0,
              "R9 hold under stall", out_key, e);
      end
      out_ready = 1'b1;
      @(posedge clk);
      @(negedge clk);
      out_ready = 1'b0;
      check(out_valid === 1'b0, "R9 drained", {127'd0, out_valid}, 128'd0);
    end
    check(cmd_ready === 1'b1 && in_ready === 1'b0, "R10 idle after last",
          {126'd0, cmd_ready, in_ready}, 128'd2);
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [127:0] fk;
    void'($urandom(32'd20240611));
    build_sbox();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check(cmd_ready === 1'b1 && in_ready === 1'b0 && out_valid === 1'b0 &&
          cmd_illegal === 1'b0, "R10 reset state",
          {124'd0, cmd_ready, in_ready, out_valid, cmd_illegal}, 128'h8);

    // directed known key, round 1 (R2, R3, R5)
    fk = {sw(32'h09cf4f3c), sw(32'habf71588), sw(32'h28aed2a6), sw(32'h2b7e1516)};
    run_cmd(0, 4, 3'd2, 5'd1, fk, 1'b1, 0);
    // independent literal for the known vector
    check(exp_next(fk, 5'd1) === {sw(32'h2a6c7605), sw(32'h23a33939),
          sw(32'h88542cb1), sw(32'ha0fafe17)}, "R2 known vector reference",
          exp_next(fk, 5'd1), 128'd0);

    // every immediate including bit 4 set (R1, R2)
    for (int i = 0; i < 32; i++) run_cmd(0, 4, 3'd2, 5'(i), '0, 1'b0, 1);

    // multiple groups with back-pressure (R7, R9)
    run_cmd(8, 24, 3'd2, 5'd10, '0, 1'b0, 3);

    // illegal commands (R6)
    run_cmd(0, 8, 3'd1, 5'd3, '0, 1'b0, 0);
    run_cmd(2, 8, 3'd2, 5'd3, '0, 1'b0, 0);
    run_cmd(0, 6, 3'd2, 5'd3, '0, 1'b0, 0);
    run_cmd(0, 8, 3'd3, 5'd3, '0, 1'b0, 0);

    // empty range (R7)
    run_cmd(16, 8, 3'd2, 5'd4, '0, 1'b0, 0);
    run_cmd(12, 12, 3'd2, 5'd4, '0, 1'b0, 0);

    // constrained random
    for (int n = 0; n < 40; n++) begin
      int vs, vl;
      logic [2:0] sew;
      vs = int'($urandom() % 24);
      vl = int'($urandom() % 40);
      if ($urandom() % 4 != 0) begin
        vs = vs & ~3;
        vl = vl & ~3;
      end
      sew = ($urandom() % 5 == 0) ? 3'($urandom() % 8) : 3'd2;
      run_cmd(vs, vl, sew, 5'($urandom()), '0, 1'b0, 2);
    end

    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule